// File: doc/BRIEF.md
# Two-Stage Watchdog with Interrupt Prewarning

This block is a watchdog down-counter that gives software one last chance before the chip is reset. Software arms it with a single write that carries an enable bit and an 8-bit count. The counter then decrements on each cycle in which the tick strobe is high. A nominal 760 Hz rate is intended, delivered as a one-cycle strobe from a shared prescaler. If software does not write again before the count runs out, the block raises a level non-maskable interrupt request. It then reloads the counter with a short grace count, ten ticks by default.

A handler that writes the watchdog during the grace window drops the interrupt and restarts the counter with the new value. If the grace count also runs out first, the block raises its system reset request. That request stays high until the block's own reset. The grace countdown runs once. After the reset request fires, the counter stops and further writes have no effect.

Top module: `wdog_prewarn`

## Requirements
- R1: After rst_ni is released, nmi_o and sys_rst_o are 0 and the watchdog is disarmed: ticks without a prior write never raise either output.
- R2: A write (wr_i=1) with wr_en_i=1 and wr_count_i=N (1..255) arms the watchdog. nmi_o rises in the clock cycle of the N-th tick that follows the write, and not earlier.
- R3: A write with wr_count_i=0 counts as 256 ticks.
- R4: The counter advances only on cycles with tick_i=1. Cycles without a tick change neither output.
- R5: On the first expiry nmi_o goes to 1 and stays at 1 while the grace count of GRACE_TICKS ticks (default 10) runs. sys_rst_o stays 0 for the first GRACE_TICKS-1 of those ticks.
- R6: On the GRACE_TICKS-th tick after the first expiry, with no write in between, sys_rst_o goes to 1. It stays at 1 until rst_ni, and writes made while it is high are ignored.
- R7: A write while nmi_o is 1, made before sys_rst_o rises, clears nmi_o on the next edge and restarts the counter with the new count, so no reset request follows.
- R8: A write with wr_en_i=0 disarms the watchdog and clears nmi_o. No tick raises either output until the next write with wr_en_i=1.
- R9: When a write and a tick arrive in the same cycle, the write takes effect and that tick is not counted.
- R10: Once sys_rst_o is high the grace count does not reload, and nmi_o keeps its value whatever ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle count strobe |
| wr_i | input | 1 | Watchdog write strobe (restart) |
| wr_en_i | input | 1 | Enable bit carried by the write |
| wr_count_i | input | CNT_W | Count carried by the write; 0 means 2**CNT_W |
| nmi_o | output | 1 | Level non-maskable interrupt request |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
The properties assume that tick_i and wr_i are synchronous, one-cycle strobes sampled at the rising edge. They also assume that GRACE_TICKS is at least one and fits in the counter. The stimulus changes every input only at the falling edge and holds it for exactly one cycle. It keeps the grace parameter at its default. It raises wr_i together with tick_i only in the case where that coincidence is the subject of the check.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_OFF   = 2'd0,
    WD_RUN   = 2'd1,
    WD_GRACE = 2'd2,
    WD_FIRED = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned LW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] load_val_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (load_i)                               cnt_q <= load_val_i;
    else if (run_i && tick_i && (cnt_q != '0))     cnt_q <= cnt_q - 1'b1;
  end

  // last tick of the current count
  assign expire_o = run_i && tick_i && (cnt_q == LW'(1));
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
  import wdog_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wr_en_i,
  input  logic expire_i,
  output logic run_o,
  output logic load_o,
  output logic sel_grace_o,
  output logic nmi_o,
  output logic sys_rst_o
);
  wd_state_e state_q, state_d;
  logic nmi_q, nmi_d, rst_q, rst_d;
  logic wr_ok;

  assign wr_ok = wr_i && (state_q != WD_FIRED);

  always_comb begin
    state_d = state_q;
    nmi_d   = nmi_q;
    rst_d   = rst_q;
    if (wr_ok) begin
      state_d = wr_en_i ? WD_RUN : WD_OFF;
      nmi_d   = 1'b0;
    end else if (expire_i) begin
      unique case (state_q)
        WD_RUN: begin
          state_d = WD_GRACE;
          nmi_d   = 1'b1;
        end
        WD_GRACE: begin
          state_d = WD_FIRED;
          rst_d   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_OFF;
      nmi_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      nmi_q   <= nmi_d;
      rst_q   <= rst_d;
    end
  end

  assign run_o       = (state_q == WD_RUN) || (state_q == WD_GRACE);
  assign load_o      = wr_ok || (expire_i && (state_q == WD_RUN));
  assign sel_grace_o = !wr_ok;
  assign nmi_o       = nmi_q;
  assign sys_rst_o   = rst_q;
endmodule

// File: rtl/wdog_prewarn.sv
module wdog_prewarn #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned GRACE_TICKS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_count_i,
  output logic             nmi_o,
  output logic             sys_rst_o
);
  localparam int unsigned LW = CNT_W + 1;
  localparam logic [LW-1:0] GRACE_V = LW'(GRACE_TICKS);
  localparam logic [LW-1:0] FULL_V  = LW'(1) << CNT_W;

  logic          run, load, sel_grace, expire;
  logic [LW-1:0] wr_val, load_val;

  // zero count means a full wrap
  assign wr_val   = (wr_count_i == '0) ? FULL_V : {1'b0, wr_count_i};
  assign load_val = sel_grace ? GRACE_V : wr_val;

  wdog_counter #(.LW(LW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .run_i      (run),
    .tick_i     (tick_i),
    .expire_o   (expire)
  );

  wdog_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .wr_en_i     (wr_en_i),
    .expire_i    (expire),
    .run_o       (run),
    .load_o      (load),
    .sel_grace_o (sel_grace),
    .nmi_o       (nmi_o),
    .sys_rst_o   (sys_rst_o)
  );
endmodule

// File: rtl/wdog_prewarn_chk.sv
module wdog_prewarn_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic wr_i,
  input logic wr_en_i,
  input logic nmi_o,
  input logic sys_rst_o
);
  p_rst_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> sys_rst_o);

  p_rst_implies_nmi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> nmi_o);

  p_wr_clears_nmi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sys_rst_o) |=> !nmi_o);

  p_no_tick_no_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !$rose(nmi_o) && !$rose(sys_rst_o));

  p_disable_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_en_i && !sys_rst_o) |=> !nmi_o && !sys_rst_o);

  p_wr_beats_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sys_rst_o) |=> !sys_rst_o);

  p_fired_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> $stable(nmi_o));
endmodule

bind wdog_prewarn wdog_prewarn_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_i      (wr_i),
  .wr_en_i   (wr_en_i),
  .nmi_o     (nmi_o),
  .sys_rst_o (sys_rst_o)
);

// File: tb/wdog_prewarn_tb.sv
module wdog_prewarn_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GRACE = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, wr_i = 1'b0, wr_en_i = 1'b0;
  logic [7:0] wr_count_i = '0;
  logic       nmi_o, sys_rst_o;

  typedef struct {
    logic  nmi;
    logic  rst;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_prewarn u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
    .wr_en_i(wr_en_i), .wr_count_i(wr_count_i),
    .nmi_o(nmi_o), .sys_rst_o(sys_rst_o)
  );

  task automatic check(logic an, logic ar, logic en, logic er, string tag);
    n_chk++;
    if (an !== en || ar !== er) begin
      n_fail++;
      $display("FAIL %s: nmi/rst actual %b/%b expected %b/%b", tag, an, ar, en, er);
    end
  endtask

  // monitor: one expected item per clock edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(nmi_o, sys_rst_o, e.nmi, e.rst, e.tag);
    end
  end

  task automatic step(bit tk, bit wr, bit en, logic [7:0] c, bit xn, bit xr, string tag);
    @(negedge clk);
    tick_i = tk; wr_i = wr; wr_en_i = en; wr_count_i = c;
    exp_q.push_back('{xn, xr, tag});
  endtask

  task automatic ticks(int n, bit xn, bit xr, string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 8'd0, xn, xr, tag);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    tick_i = 0; wr_i = 0;
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(nmi_o, sys_rst_o, 1'b0, 1'b0, "R1 reset state");
  endtask

  initial begin
    apply_reset();
    ticks(20, 0, 0, "R1 disarmed after reset");

    // restart before expiry
    step(0, 1, 1, 8'd5, 0, 0, "R2 arm 5");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 8'd0, 0, 0, "R4 no tick");
    ticks(3, 0, 0, "R2 counting");
    step(0, 1, 1, 8'd4, 0, 0, "R7 restart early");
    ticks(3, 0, 0, "R2 reloaded count");
    step(0, 0, 0, 8'd0, 0, 0, "R4 no tick");
    ticks(1, 1, 0, "R2 nmi on 4th tick");

    // restart during grace
    ticks(GRACE - 1, 1, 0, "R5 grace running");
    step(0, 1, 1, 8'd2, 0, 0, "R7 grace write clears nmi");
    ticks(1, 0, 0, "R7 new count");
    ticks(1, 1, 0, "R5 second first-expiry");

    // no restart: reset request
    ticks(GRACE - 1, 1, 0, "R5 grace running");
    ticks(1, 1, 1, "R6 reset after grace");
    step(0, 1, 1, 8'd3, 1, 1, "R6 write ignored when fired");
    ticks(20, 1, 1, "R10 frozen after fire");
    step(0, 1, 0, 8'd3, 1, 1, "R6 disable write ignored");
    @(negedge clk); tick_i = 0; wr_i = 0;
    @(negedge clk);
    apply_reset();

    // zero count means 256
    step(0, 1, 1, 8'd0, 0, 0, "R3 arm 0");
    ticks(255, 0, 0, "R3 255 ticks quiet");
    ticks(1, 1, 0, "R3 nmi on 256th");

    // disable clears and silences
    step(0, 1, 0, 8'd1, 0, 0, "R8 disable clears nmi");
    ticks(30, 0, 0, "R8 disabled quiet");

    // write and tick coincide
    step(1, 1, 1, 8'd2, 0, 0, "R9 write with tick");
    ticks(1, 0, 0, "R9 tick not counted");
    ticks(1, 1, 0, "R9 nmi on 2nd tick");

    step(0, 0, 0, 8'd0, 1, 0, "R4 idle holds");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule